// File: doc/BRIEF.md
# Configuration Download Controller

This block fills the live configuration register file from the configuration region of a nonvolatile array. That region holds sixteen 32-byte pages starting at address 0xF800. Only the first seven pages carry configuration. Page 7 is reserved and pages 8 to 15 hold customer data, so the controller never reads either. Each configuration byte sits at the nonvolatile address formed by putting 0xF8 in front of its register address. Register n therefore comes from nonvolatile location 0xF800+n.

A copy starts in two ways. The first is automatic, as the block comes out of reset. The second is a software write of 1 to bit 0 of register address 0xD8, which sets a user-request flag. The controller then reads 224 bytes in ascending order, one at a time. Each byte goes to the register file over a valid/ready write stream.

While a copy runs, `busy` is high, and the host bus interface uses it to hold off register access. The register-file side may apply back-pressure at any time: `ram_wr_valid` then stays high with address and data unchanged until `ram_wr_ready` is sampled high. A transfer happens only on a rising edge where both are high. The nonvolatile port is a plain synchronous read with one cycle of latency.

Top module: `cfg_download`

## Requirements
- R1: Out of reset a download starts with no stimulus: `busy` is 1 while `rst_n` is low and stays 1 until that download completes; `user_flag`, `done` and `ram_wr_valid` are 0 during reset.
- R2: A download writes exactly 224 bytes, to register addresses 0x00 through 0xDF, in ascending order, each address once.
- R3: The byte written to register n equals the nonvolatile byte at address 0xF800+n. No nonvolatile read ever addresses anything outside 0xF800..0xF8DF, so pages 7 to 15 are never read.
- R4: The nonvolatile read data is taken one cycle after `nv_rd_en`. With `ram_wr_ready` held at 1, each byte takes 3 cycles, so `busy` stays high for exactly 672 cycles after a software trigger edge.
- R5: Once raised, `ram_wr_valid` stays 1 with stable `ram_wr_addr` and `ram_wr_data` until a cycle in which `ram_wr_ready` is 1.
- R6: A register write to address 0xD8 with data bit 0 equal to 1, accepted while idle, sets `user_flag` (the value of bit 0 of register 0xD8) and raises `busy` at the same edge.
- R7: A write to 0xD8 with data bit 0 equal to 0, or a write to any other address, changes neither `busy` nor `user_flag`.
- R8: A trigger write that arrives while `busy` is 1 is ignored: `user_flag` keeps its value and no extra download follows.
- R9: `user_flag` clears at the same edge at which `busy` falls at the end of a download.
- R10: `done` is a single-cycle pulse, high in exactly the first cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release starts the power-up download |
| reg_wr_en | input | 1 | Register write strobe from the host bus interface |
| reg_wr_addr | input | 8 | Register write address |
| reg_wr_data | input | 8 | Register write data |
| user_flag | output | 1 | Bit 0 of register 0xD8 (user download request) |
| nv_rd_en | output | 1 | Nonvolatile read enable |
| nv_rd_addr | output | 16 | Nonvolatile read address |
| nv_rd_data | input | 8 | Nonvolatile read data, valid one cycle after the enable |
| ram_wr_valid | output | 1 | Register-file write request |
| ram_wr_ready | input | 1 | Register-file accepts the write |
| ram_wr_addr | output | 8 | Register-file write address |
| ram_wr_data | output | 8 | Register-file write data |
| busy | output | 1 | Download in progress; register access is blocked |
| done | output | 1 | One-cycle pulse when a download finishes |

## Verification
A trigger write takes effect at the edge that samples it. `busy` and `user_flag` are therefore checked at the following falling edge. Each register-file write is due two cycles after its nonvolatile read, plus any cycles of back-pressure. The bench sets `ram_wr_ready` at each falling edge and then samples valid and ready together, so each sample describes the transfer at the next rising edge. That transfer is compared against a queue of expected address/data pairs that was filled when the trigger was issued. `done` is due in the first cycle after the final transfer, the same cycle in which `busy` and `user_flag` are first seen low. With ready held high, the 672 cycles of `busy` are counted falling edge by falling edge.

// File: rtl/cfgdl_pkg.sv
package cfgdl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_LATCH = 2'd2,
    ST_WRITE = 2'd3
  } dl_state_e;
endpackage

// File: rtl/cfgdl_trigger.sv
module cfgdl_trigger #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 'hD8,
  parameter int CTRL_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              finish,
  output logic              start,
  output logic              user_flag
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic hit;
  assign hit   = wr_en && (wr_addr == CTRL_A) && wr_data[CTRL_BIT];
  assign start = hit && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      user_flag <= 1'b0;
    else if (finish) user_flag <= 1'b0;
    else if (start)  user_flag <= 1'b1;
  end

  // R8: a write during a download leaves the request bit alone
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish && wr_en) |=> $stable(user_flag));
  // R9: bit clears together with the end of the download
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !user_flag);
endmodule

// File: rtl/cfgdl_index.sv
module cfgdl_index #(
  parameter int COUNT   = 224,
  parameter int ADDR_W  = 8,
  parameter int NV_AW   = 16,
  parameter int NV_BASE = 'hF800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic              idx_last,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [NV_AW-1:0]  nv_addr
);
  localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [NV_AW-1:0] BASE = NV_AW'(NV_BASE);
  localparam bit ALIGNED = ((NV_BASE % (1 << ADDR_W)) == 0) && (NV_AW > ADDR_W);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (step)  idx <= idx + 1'b1;
  end

  assign idx_last = (idx == IDX_W'(COUNT - 1));
  assign ram_addr = ADDR_W'(idx);

  generate
    if (ALIGNED) begin : g_prefix
      assign nv_addr = {BASE[NV_AW-1:ADDR_W], ram_addr};
    end else begin : g_adder
      assign nv_addr = BASE + NV_AW'(idx);
    end
  endgenerate

  // R2: the walk never steps beyond the last configuration byte
  p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !idx_last);
endmodule

// File: rtl/cfgdl_seq.sv
module cfgdl_seq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              idx_last,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_ready,
  output logic              rd_en,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              finish,
  output logic              step,
  output logic              clear
);
  import cfgdl_pkg::*;

  dl_state_e state, state_nx;
  logic      xfer;

  assign xfer     = (state == ST_WRITE) && wr_ready;
  assign finish   = xfer && idx_last;
  assign step     = xfer && !idx_last;
  assign clear    = (state == ST_IDLE) && start;
  assign rd_en    = (state == ST_READ);
  assign wr_valid = (state == ST_WRITE);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start) state_nx = ST_READ;
      ST_READ:  state_nx = ST_LATCH;
      ST_LATCH: state_nx = ST_WRITE;
      ST_WRITE: if (wr_ready) state_nx = idx_last ? ST_IDLE : ST_READ;
      default:  state_nx = ST_IDLE;
    endcase
  end

  // Reset lands in ST_READ: the power-up download begins on release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_READ;
      wr_data <= '0;
      done    <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= finish;
      if (state == ST_LATCH) wr_data <= rd_data;
    end
  end

  // R5: request held steady under back-pressure
  p_hold_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
  // R10: done lasts one cycle and only appears once idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6: an accepted trigger makes the block busy at the next edge
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/cfg_download.sv
module cfg_download #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int NV_AW      = 16,
  parameter int NV_BASE    = 'hF800,
  parameter int PAGE_BYTES = 32,
  parameter int CFG_PAGES  = 7,
  parameter int CTRL_ADDR  = 'hD8,
  parameter int CTRL_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic              user_flag,
  output logic              nv_rd_en,
  output logic [NV_AW-1:0]  nv_rd_addr,
  input  logic [DATA_W-1:0] nv_rd_data,
  output logic              ram_wr_valid,
  input  logic              ram_wr_ready,
  output logic [ADDR_W-1:0] ram_wr_addr,
  output logic [DATA_W-1:0] ram_wr_data,
  output logic              busy,
  output logic              done
);
  localparam int COUNT = PAGE_BYTES * CFG_PAGES;
  localparam logic [NV_AW-1:0] NV_LO = NV_AW'(NV_BASE);
  localparam logic [NV_AW-1:0] NV_HI = NV_AW'(NV_BASE + COUNT - 1);

  logic start, finish, step, clear, idx_last;

  cfgdl_trigger #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .CTRL_BIT(CTRL_BIT)
  ) u_trigger (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .busy(busy), .finish(finish),
    .start(start), .user_flag(user_flag)
  );

  cfgdl_index #(
    .COUNT(COUNT), .ADDR_W(ADDR_W), .NV_AW(NV_AW), .NV_BASE(NV_BASE)
  ) u_index (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
    .idx_last(idx_last), .ram_addr(ram_wr_addr), .nv_addr(nv_rd_addr)
  );

  cfgdl_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .idx_last(idx_last),
    .rd_data(nv_rd_data), .wr_ready(ram_wr_ready), .rd_en(nv_rd_en),
    .wr_valid(ram_wr_valid), .wr_data(ram_wr_data), .busy(busy),
    .done(done), .finish(finish), .step(step), .clear(clear)
  );

  // R3: reads stay inside the configuration pages
  p_nv_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nv_rd_en |-> ((nv_rd_addr >= NV_LO) && (nv_rd_addr <= NV_HI)));
  // R5: write address also held under back-pressure
  p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_valid && !ram_wr_ready) |=> $stable(ram_wr_addr));
endmodule

// File: tb/cfg_download_bench.sv
module cfg_download_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES = 224;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [7:0] reg_wr_addr = '0, reg_wr_data = '0;
  logic user_flag, nv_rd_en, ram_wr_valid, busy, done;
  logic [15:0] nv_rd_addr;
  logic [7:0] nv_rd_data = '0;
  logic ram_wr_ready = 1'b1;
  logic [7:0] ram_wr_addr, ram_wr_data;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  logic [7:0] seed = 8'h5A;
  bit bp_mode = 1'b0;
  logic [7:0] lfsr = 8'h1;
  int xfers = 0, done_cnt = 0, busy_cyc = 0, cyc = 0;
  logic prev_busy = 1'b1, prev_flag = 1'b0;
  bit expect_flag_drop = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_download u_cfg_download (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .user_flag(user_flag), .nv_rd_en(nv_rd_en),
    .nv_rd_addr(nv_rd_addr), .nv_rd_data(nv_rd_data), .ram_wr_valid(ram_wr_valid),
    .ram_wr_ready(ram_wr_ready), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] nv_byte(input logic [15:0] a, input logic [7:0] s);
    return (a[7:0] * 8'd37) ^ s ^ a[15:8] ^ {a[3:0], a[7:4]};
  endfunction

  // nonvolatile model: one cycle read latency
  always @(posedge clk) if (nv_rd_en) nv_rd_data <= nv_byte(nv_rd_addr, seed);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_expected();
    for (int n = 0; n < NBYTES; n++)
      exp_q.push_back({8'(n), nv_byte(16'hF800 + 16'(n), seed)});
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: set ready, then sample what the next rising edge will see
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ram_wr_ready = bp_mode ? lfsr[0] : 1'b1;
    #1;
    if (rst_n) begin
      if (nv_rd_en)
        check(nv_rd_addr >= 16'hF800 && nv_rd_addr <= 16'hF8DF, "R3 nv range",
              nv_rd_addr, 16'hF800);
      if (ram_wr_valid && ram_wr_ready) begin
        xfers++;
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected write", ram_wr_addr, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(ram_wr_addr == e[15:8], "R2 address order", ram_wr_addr, e[15:8]);
          check(ram_wr_data == e[7:0], "R3 data", ram_wr_data, e[7:0]);
        end
      end
      if (busy) busy_cyc++;
      if (done) begin
        done_cnt++;
        check(!busy && prev_busy, "R10 done after busy falls", busy, 0);
        check(!user_flag, "R9 flag cleared", user_flag, 0);
        if (expect_flag_drop) check(prev_flag, "R9 flag was set", prev_flag, 1);
      end
      if (prev_busy && !busy) check(done, "R10 done on busy fall", done, 1);
      prev_busy = busy;
      prev_flag = user_flag;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_sim();
  end

  task automatic wait_done(input int target);
    for (int i = 0; i < 5000 && done_cnt < target; i++) @(negedge clk);
    check(done_cnt == target, "R2 download completes", done_cnt, target);
  endtask

  initial begin
    push_expected();
    repeat (4) @(negedge clk);
    #2;
    check(busy == 1'b1, "R1 busy in reset", busy, 1);
    check(user_flag == 1'b0 && done == 1'b0 && ram_wr_valid == 1'b0,
          "R1 reset outputs", {user_flag, done, ram_wr_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (20) @(negedge clk);
    #2 check(busy == 1'b1, "R1 busy after release", busy, 1);
    // R8: trigger during power-up download is ignored
    reg_write(8'hD8, 8'h01);
    #2 check(user_flag == 1'b0, "R8 flag during power-up", user_flag, 0);
    wait_done(1);
    check(exp_q.size() == 0 && xfers == NBYTES, "R2 byte count", xfers, NBYTES);
    repeat (5) @(negedge clk);
    #2 check(!busy && !user_flag, "R8 no extra download", {busy, user_flag}, 0);

    // R7: non-triggering writes
    reg_write(8'hD8, 8'hFE);
    #2 check(!busy && !user_flag, "R7 bit0 clear ignored", {busy, user_flag}, 0);
    reg_write(8'hD7, 8'h01);
    #2 check(!busy && !user_flag, "R7 other address ignored", {busy, user_flag}, 0);
    repeat (5) @(negedge clk);
    check(xfers == NBYTES, "R7 no writes", xfers, NBYTES);

    // R6/R4: user download with ready held high, new contents
    seed = 8'hC3;
    push_expected();
    busy_cyc = 0;
    expect_flag_drop = 1'b1;
    reg_write(8'hD8, 8'h01);
    #2 check(busy && user_flag, "R6 trigger accepted", {busy, user_flag}, 3);
    repeat (100) @(negedge clk);
    // R8: second trigger mid-download
    reg_write(8'hD8, 8'h01);
    #2 check(user_flag == 1'b1, "R8 flag unchanged", user_flag, 1);
    wait_done(2);
    check(busy_cyc == 3 * NBYTES, "R4 busy length", busy_cyc, 3 * NBYTES);
    check(exp_q.size() == 0 && xfers == 2 * NBYTES, "R2 user count", xfers, 2 * NBYTES);
    repeat (10) @(negedge clk);
    check(xfers == 2 * NBYTES && !busy, "R8 no repeat", xfers, 2 * NBYTES);

    // R5: download under back-pressure
    seed = 8'h27;
    push_expected();
    bp_mode = 1'b1;
    reg_write(8'hD8, 8'h03);
    #2 check(busy && user_flag, "R6 trigger with other bits", {busy, user_flag}, 3);
    wait_done(3);
    check(exp_q.size() == 0 && xfers == 3 * NBYTES, "R5 all bytes under back-pressure",
          xfers, 3 * NBYTES);
    bp_mode = 1'b0;
    repeat (5) @(negedge clk);
    finish_sim();
  end
endmodule